// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds one register that is replicated across a grid of hardware units, arranged as a number of groups with a fixed number of instances in each group. Every unit keeps its own copy, and all copies answer at a single bus offset. A second offset holds a steering selector with three fields: a group number, an instance number and a broadcast flag. On every access to the shared offset, the selector decides which copy or copies are reached.

A write with the broadcast flag set updates every available copy with one value. A write with the flag clear updates only the steered copy. A read always returns the single steered copy, whatever the flag says. The block takes a per-unit availability mask as an input. It marks units that are fused off or power-gated. An access steered to an unavailable unit ends quietly: a read returns zero and a write changes nothing. Read data is registered, and the selector itself can be read back.

Top module: `rrb_steer_bank`

## Requirements
- R1: After reset, the selector reads back as 0x0001_0000 (broadcast flag set, group 0, instance 0), and every copy reads as zero.
- R2: In the selector word, the instance field sits at bits [1:0], the group field at bits [9:8] and the broadcast flag at bit 16 (defaults: 4 groups, 4 instances). All other bits read zero. The selector changes only when the selector offset (0x00) is written.
- R3: A write to the shared offset (0x04) with the broadcast flag set stores the write data in every copy whose availability bit is 1. Unit index is group*instances+instance.
- R4: A broadcast write leaves the copies of unavailable units unchanged. They keep their old value when they later become available.
- R5: A write to the shared offset with the broadcast flag clear updates only the copy at the steered group and instance.
- R6: A write with the broadcast flag clear that is steered to an unavailable unit changes no copy.
- R7: A read of the shared offset returns the steered copy whether the broadcast flag is set or clear.
- R8: A read of the shared offset steered to an unavailable unit returns zero.
- R9: Read data appears on the clock edge that samples the read enable and holds while the read enable is low.
- R10: When a read and a write fall in the same cycle at the same offset, the read returns the value from before the write.
- R11: Reads of any offset other than 0x00 and 0x04 return zero, and writes to them change neither the selector nor any copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Access offset |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| unit_avail | input | N_GROUPS*N_INST | Per-unit availability, 1 = present and powered |
| bus_rdata | output | DW | Registered read data |

## Verification
A read and a write can land in the same cycle. This happens at the shared offset, where the write changes a copy that the read is returning, and at the selector offset, where the write changes the selector that the read reports. The bench drives both enables together in one cycle in each case. It expects the pre-write value on the read data, and then expects the new value on a following read. A behavioural model, updated read-first on each edge, also compares the read data on every clock through all other traffic. This covers availability changes made between accesses.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    // Bit positions of the selector fields; software decodes these.
    localparam int INST_LSB = 0;
    localparam int GRP_LSB  = 8;
    localparam int MC_BIT   = 16;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SEL  = 2'd1,
        TGT_REP  = 2'd2
    } tgt_e;

    function automatic int width_of(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rrb_sel_decode.sv
module rrb_sel_decode #(
    parameter int N_GROUPS = 4,
    parameter int N_INST   = 4,
    parameter int GW       = 2,
    parameter int IW       = 2,
    parameter int UW       = 4
) (
    input  logic [GW-1:0]              grp,
    input  logic [IW-1:0]              inst,
    input  logic [N_GROUPS*N_INST-1:0] avail,
    output logic [UW-1:0]              idx,
    output logic                       hit
);
    localparam int NU = N_GROUPS * N_INST;

    int  lin;
    logic in_range;

    always_comb begin
        in_range = (int'(grp) < N_GROUPS) && (int'(inst) < N_INST);
        lin      = int'(grp) * N_INST + int'(inst);
        idx      = in_range ? UW'(lin) : '0;
        hit      = in_range && (lin < NU) && avail[idx];
    end

endmodule

// File: rtl/rrb_copy_store.sv
module rrb_copy_store #(
    parameter int NU = 16,
    parameter int DW = 32,
    parameter int UW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mc_we,
    input  logic            uc_we,
    input  logic [UW-1:0]   uc_idx,
    input  logic [DW-1:0]   wdata,
    input  logic [NU-1:0]   avail,
    output logic [NU*DW-1:0] copies
);

    for (genvar u = 0; u < NU; u++) begin : g_slot
        logic [DW-1:0] slot_d;
        logic [DW-1:0] slot_q;
        logic          take;

        always_comb begin
            take   = (mc_we && avail[u]) || (uc_we && (uc_idx == UW'(u)));
            slot_d = take ? wdata : slot_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign copies[u*DW +: DW] = slot_q;
    end

endmodule

// File: rtl/rrb_read_mux.sv
module rrb_read_mux #(
    parameter int NU = 16,
    parameter int DW = 32,
    parameter int UW = 4
) (
    input  logic [NU*DW-1:0] copies,
    input  logic [UW-1:0]    idx,
    input  logic             hit,
    output logic [DW-1:0]    data
);
    always_comb begin
        data = '0;
        if (hit) data = copies[int'(idx)*DW +: DW];
    end
endmodule

// File: rtl/rrb_steer_bank.sv
module rrb_steer_bank
    import rrb_pkg::*;
#(
    parameter int             N_GROUPS = 4,
    parameter int             N_INST   = 4,
    parameter int             DW       = 32,
    parameter int             AW       = 8,
    parameter logic [AW-1:0]  SEL_OFS  = 'h00,
    parameter logic [AW-1:0]  REP_OFS  = 'h04
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    input  logic                       bus_we,
    input  logic                       bus_re,
    input  logic [N_GROUPS*N_INST-1:0] unit_avail,
    output logic [DW-1:0]              bus_rdata
);
    localparam int NU = N_GROUPS * N_INST;
    localparam int GW = width_of(N_GROUPS);
    localparam int IW = width_of(N_INST);
    localparam int UW = width_of(NU);

    typedef struct packed {
        logic [GW-1:0] grp;
        logic [IW-1:0] inst;
        logic          mc;
        logic [DW-1:0] rdata;
    } st_t;

    localparam st_t ST_RST = '{grp: '0, inst: '0, mc: 1'b1, rdata: '0};

    st_t             st_d, st_q;
    tgt_e            tgt;
    logic [DW-1:0]   sel_rb;
    logic [DW-1:0]   rep_val;
    logic [UW-1:0]   steer_idx;
    logic            steer_hit;
    logic            mc_we, uc_we;
    logic [NU*DW-1:0] copy_flat;

    rrb_sel_decode #(
        .N_GROUPS(N_GROUPS), .N_INST(N_INST), .GW(GW), .IW(IW), .UW(UW)
    ) u_dec (
        .grp   (st_q.grp),
        .inst  (st_q.inst),
        .avail (unit_avail),
        .idx   (steer_idx),
        .hit   (steer_hit)
    );

    rrb_copy_store #(.NU(NU), .DW(DW), .UW(UW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .mc_we  (mc_we),
        .uc_we  (uc_we),
        .uc_idx (steer_idx),
        .wdata  (bus_wdata),
        .avail  (unit_avail),
        .copies (copy_flat)
    );

    rrb_read_mux #(.NU(NU), .DW(DW), .UW(UW)) u_mux (
        .copies (copy_flat),
        .idx    (steer_idx),
        .hit    (steer_hit),
        .data   (rep_val)
    );

    always_comb begin
        st_d = st_q;

        if (bus_addr == SEL_OFS)      tgt = TGT_SEL;
        else if (bus_addr == REP_OFS) tgt = TGT_REP;
        else                          tgt = TGT_NONE;

        sel_rb                  = '0;
        sel_rb[INST_LSB +: IW]  = st_q.inst;
        sel_rb[GRP_LSB +: GW]   = st_q.grp;
        sel_rb[MC_BIT]          = st_q.mc;

        // Reads use the state before this cycle's write.
        if (bus_re) begin
            case (tgt)
                TGT_SEL: st_d.rdata = sel_rb;
                TGT_REP: st_d.rdata = rep_val;
                default: st_d.rdata = '0;
            endcase
        end

        if (bus_we && tgt == TGT_SEL) begin
            st_d.inst = bus_wdata[INST_LSB +: IW];
            st_d.grp  = bus_wdata[GRP_LSB +: GW];
            st_d.mc   = bus_wdata[MC_BIT];
        end

        mc_we = bus_we && (tgt == TGT_REP) && st_q.mc;
        uc_we = bus_we && (tgt == TGT_REP) && !st_q.mc && steer_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/rrb_steer_chk.sv
module rrb_steer_chk #(
    parameter int            N_GROUPS = 4,
    parameter int            N_INST   = 4,
    parameter int            DW       = 32,
    parameter int            AW       = 8,
    parameter int            GW       = 2,
    parameter int            IW       = 2,
    parameter logic [AW-1:0] SEL_OFS  = 'h00,
    parameter logic [AW-1:0] REP_OFS  = 'h04
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [AW-1:0]                     bus_addr,
    input logic                              bus_we,
    input logic                              bus_re,
    input logic [N_GROUPS*N_INST-1:0]        unit_avail,
    input logic [DW-1:0]                     bus_rdata,
    input logic [GW-1:0]                     sel_grp,
    input logic [IW-1:0]                     sel_inst,
    input logic                              sel_mc,
    input logic [N_GROUPS*N_INST*DW-1:0]     copies
);
    logic          live_c;
    logic [DW-1:0] cur_copy;
    logic          at_sel, at_rep;

    always_comb begin
        live_c   = 1'b0;
        cur_copy = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            for (int i = 0; i < N_INST; i++) begin
                if (int'(sel_grp) == g && int'(sel_inst) == i) begin
                    live_c   = unit_avail[g*N_INST+i];
                    cur_copy = copies[(g*N_INST+i)*DW +: DW];
                end
            end
        end
        at_sel = (bus_addr == SEL_OFS);
        at_rep = (bus_addr == REP_OFS);
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !at_sel && !at_rep) |=> (bus_rdata == '0)); // R11

    AST_DEAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && at_rep && !live_c) |=> (bus_rdata == '0)); // R8

    AST_LIVE_READ_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && at_rep && live_c) |=> (bus_rdata == $past(cur_copy))); // R7

    AST_DEAD_UC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && at_rep && !sel_mc && !live_c) |=> $stable(copies)); // R6

    AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && at_sel) |=> $stable({sel_grp, sel_inst, sel_mc})); // R2

endmodule

bind rrb_steer_bank rrb_steer_chk #(
    .N_GROUPS(N_GROUPS), .N_INST(N_INST), .DW(DW), .AW(AW),
    .GW(GW), .IW(IW), .SEL_OFS(SEL_OFS), .REP_OFS(REP_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .unit_avail (unit_avail),
    .bus_rdata  (bus_rdata),
    .sel_grp    (st_q.grp),
    .sel_inst   (st_q.inst),
    .sel_mc     (st_q.mc),
    .copies     (copy_flat)
);

// File: tb/rrb_steer_bank_tb.sv
`timescale 1ns/1ps
module rrb_steer_bank_tb;
    localparam int NG = 4;
    localparam int NI = 4;
    localparam int NU = NG * NI;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [7:0] SEL = 8'h00;
    localparam logic [7:0] REP = 8'h04;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [NU-1:0] unit_avail = '1;
    logic [DW-1:0] bus_rdata;

    always #4 clk = ~clk;

    rrb_steer_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .unit_avail(unit_avail),
        .bus_rdata(bus_rdata)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    running = 0;
    string cur_req = "R1";

    // Behavioural reference model
    logic [DW-1:0] m_copy [NU];
    int            m_grp, m_inst, mid;
    bit            m_mc, mlive;
    logic [DW-1:0] m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NU; k++) m_copy[k] = '0;
            m_grp = 0; m_inst = 0; m_mc = 1; m_rdata = '0;
        end else begin
            mid   = m_grp * NI + m_inst;
            mlive = (m_grp < NG) && (m_inst < NI) && unit_avail[mid];
            if (bus_re) begin
                if (bus_addr == SEL)
                    m_rdata = (DW'(m_mc) << 16) | (DW'(m_grp) << 8) | DW'(m_inst);
                else if (bus_addr == REP)
                    m_rdata = mlive ? m_copy[mid] : '0;
                else
                    m_rdata = '0;
            end
            if (bus_we) begin
                if (bus_addr == SEL) begin
                    m_inst = int'(bus_wdata[1:0]);
                    m_grp  = int'(bus_wdata[9:8]);
                    m_mc   = bus_wdata[16];
                end else if (bus_addr == REP) begin
                    if (m_mc) begin
                        for (int k = 0; k < NU; k++)
                            if (unit_avail[k]) m_copy[k] = bus_wdata;
                    end else if (mlive) begin
                        m_copy[mid] = bus_wdata;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && running) begin
            n_chk++;
            if (bus_rdata !== m_rdata) begin
                n_err++;
                $display("FAIL %s per-cycle compare: rdata=%h expected=%h", cur_req, bus_rdata, m_rdata);
            end
        end
    end

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp,
                         input string what);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic op(input bit w, input bit r, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_we = w; bus_re = r; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_re = 0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        op(0, 1, a, '0);
        check(req, bus_rdata, exp, "read");
    endtask

    function automatic logic [DW-1:0] sw(input int g, input int i, input bit mc);
        return (DW'(mc) << 16) | (DW'(g) << 8) | DW'(i);
    endfunction

    task automatic sel(input int g, input int i, input bit mc);
        op(1, 0, SEL, sw(g, i, mc));
    endtask

    task automatic finish_run();
        running = 0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R9 watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        running = 1;
        @(negedge clk);

        cur_req = "R1";
        check("R1", bus_rdata, '0, "rdata after reset");
        rd_chk(SEL, 32'h0001_0000, "R1");
        rd_chk(REP, '0, "R1");

        cur_req = "R2";
        sel(3, 2, 0);
        rd_chk(SEL, 32'h0000_0302, "R2");
        op(1, 0, SEL, 32'hFFFF_FFFF);
        rd_chk(SEL, 32'h0001_0303, "R2");

        cur_req = "R3";
        unit_avail = 16'hFBDF;       // units 5 and 10 unavailable
        sel(0, 0, 1);
        op(1, 0, REP, 32'hA5A5_0001);
        for (int g = 0; g < NG; g++) begin
            for (int i = 0; i < NI; i++) begin
                int id;
                id = g * NI + i;
                sel(g, i, 1);
                if (id == 5 || id == 10) rd_chk(REP, '0, "R8");
                else                     rd_chk(REP, 32'hA5A5_0001, "R3");
            end
        end

        cur_req = "R4";
        unit_avail = '1;
        sel(1, 1, 1);
        rd_chk(REP, '0, "R4");
        sel(2, 2, 1);
        rd_chk(REP, '0, "R4");

        cur_req = "R5";
        sel(2, 1, 0);
        op(1, 0, REP, 32'h0000_1234);
        rd_chk(REP, 32'h0000_1234, "R5");
        sel(2, 0, 0);
        rd_chk(REP, 32'hA5A5_0001, "R5");
        sel(1, 1, 0);
        rd_chk(REP, '0, "R5");

        cur_req = "R6";
        sel(2, 1, 0);
        unit_avail[9] = 1'b0;
        op(1, 0, REP, 32'hFFFF_0000);
        unit_avail[9] = 1'b1;
        rd_chk(REP, 32'h0000_1234, "R6");

        cur_req = "R7";
        sel(1, 3, 1);
        rd_chk(REP, 32'hA5A5_0001, "R7");
        sel(2, 1, 1);
        rd_chk(REP, 32'h0000_1234, "R7");

        cur_req = "R9";
        repeat (3) begin
            @(negedge clk);
            check("R9", bus_rdata, 32'h0000_1234, "hold while idle");
        end
        sel(2, 0, 1);
        bus_re = 1; bus_addr = REP;
        #1;
        check("R9", bus_rdata, 32'h0000_1234, "before sampling edge");
        @(negedge clk);
        bus_re = 0;
        check("R9", bus_rdata, 32'hA5A5_0001, "after sampling edge");

        cur_req = "R10";
        sel(2, 1, 0);
        op(1, 1, REP, 32'h0000_5678);
        check("R10", bus_rdata, 32'h0000_1234, "same-cycle copy read");
        rd_chk(REP, 32'h0000_5678, "R10");
        op(1, 1, SEL, sw(0, 0, 1));
        check("R10", bus_rdata, 32'h0000_0201, "same-cycle selector read");
        rd_chk(SEL, 32'h0001_0000, "R10");

        cur_req = "R11";
        op(1, 0, 8'h20, 32'hDEAD_BEEF);
        rd_chk(8'h20, '0, "R11");
        rd_chk(SEL, 32'h0001_0000, "R11");
        rd_chk(REP, 32'hA5A5_0001, "R11");

        @(negedge clk);
        finish_run();
    end

endmodule